// File: doc/BRIEF.md
# I2C Master Start-Condition Controller

This block decides when an I2C master may put a start condition on the bus and then drives it. It receives a one-cycle software start request, watches the shared SDA and SCL lines, and knows whether the device is already master, whether the byte engine is holding the bus in a wait, and whether a request made while someone else owns the bus should be queued. Each request leads to one of four outcomes: an immediate start, a repeated start once the wait ends, a queued start that fires by itself when the bus is free again, or a refusal that sets a sticky flag.

The lines are modelled as open drain. An output high on `sda_oe` or `scl_oe` pulls that line low, and the board resolves the wired-AND. A small line watcher inside the block tracks bus ownership. A start is SDA falling while SCL is high on two samples running. A stop is SDA rising while SCL is high on two samples running. The bus counts as free only after `BUF_CYCLES` clocks with no traffic following a stop. When `start_done` pulses, the shifting logic takes over the lines.

The controller states are S_IDLE, S_QUEUED (waiting for a free bus), S_RS_WAIT (repeated start accepted, clock held low until the wait ends), S_RS_DATA (SDA released, SCL low), S_RS_CLOCK (both lines released), S_SDA_LOW (SDA pulled low, SCL high) and S_SCL_LOW (both low, `start_done`).

The transitions are as follows:
- S_IDLE goes to S_SDA_LOW for a start, to S_RS_WAIT for a restart and to S_QUEUED for a reservation.
- S_QUEUED goes to S_SDA_LOW once the bus is free.
- S_RS_WAIT goes to S_RS_DATA when the wait ends.
- S_RS_DATA goes to S_RS_CLOCK, and S_RS_CLOCK goes to S_SDA_LOW, each after `HOLD_CYCLES`.
- S_SDA_LOW goes to S_SCL_LOW after `HOLD_CYCLES`.
- S_SCL_LOW goes to S_IDLE.
- Every state goes to S_IDLE on an abort.

Top module: `i2c_start_ctrl`

## Requirements
- R1: When the device is not master and the bus is free, a start request moves to S_SDA_LOW at the next edge. There `sda_oe`=1 and `scl_oe`=0 for `HOLD_CYCLES` cycles. Then one cycle follows with both outputs at 1 and `start_done`=1, and `is_master` reads 1 from the following cycle.
- R2: When the device is master, `in_wait`=1 and the timing is legal, a start request sets `req_pending` and holds `scl_oe`=1. After `in_wait` falls, the outputs are `sda_oe`=0 and `scl_oe`=1 for `HOLD_CYCLES` cycles, then both 0 for `HOLD_CYCLES` cycles, then the R1 start waveform. `is_master` stays 1.
- R3: When the device is not master, the bus is not free and `resv_en`=1, a start request is queued (`req_pending`=1, lines released). The start waveform begins on the edge after the bus becomes free.
- R4: When the device is not master, the bus is not free and `resv_en`=0, a start request produces no waveform and no pending request, and `start_refused` reads 1 from the next cycle.
- R5: `start_refused` stays set until a `clr_flag` pulse or reset. If a refusal and `clr_flag` fall in the same cycle, the flag stays set.
- R6: `arb_lost`, `release_cmd` or `enable`=0 drops any pending or running request. From the next cycle `req_pending`=0, `is_master`=0 and both line outputs are 0.
- R7: A master request is honoured only when `in_wait`=1 and `ack_phase`=0, and in reception (`rx_mode`=1) only when `ack_en`=0 and `last_rx`=1. Otherwise `req_err` pulses for one cycle and nothing else changes.
- R8: A start request together with `stop_req`, or a start request while `req_pending`=1, pulses `req_err` for one cycle and is otherwise ignored.
- R9: The bus is busy from a detected start until a detected stop, and free `BUF_CYCLES` cycles after the stop. A detected stop clears `is_master`. A request made before the bus is free is treated as one on a busy bus.
- R10: After reset both line outputs, `start_done`, `req_pending`, `is_master`, `start_refused` and `req_err` are 0, and the bus counts as free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low aborts everything |
| start_req | input | 1 | One-cycle software start request |
| stop_req | input | 1 | One-cycle software stop request (only checked for conflict) |
| release_cmd | input | 1 | Leave communication; aborts |
| arb_lost | input | 1 | Arbitration lost; aborts |
| resv_en | input | 1 | 1 queues requests on a busy bus, 0 refuses them |
| in_wait | input | 1 | Byte engine holds the bus in the wait after the ninth clock |
| ack_phase | input | 1 | Acknowledge period in progress |
| rx_mode | input | 1 | 1 when the master is receiving |
| ack_en | input | 1 | Acknowledge generation enabled |
| last_rx | input | 1 | Final received byte has been signalled |
| clr_flag | input | 1 | Clears `start_refused` |
| sda_in | input | 1 | Resolved SDA line level |
| scl_in | input | 1 | Resolved SCL line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| start_done | output | 1 | Last cycle of a start waveform |
| req_pending | output | 1 | A request is queued, waiting or running |
| is_master | output | 1 | This device owns the bus |
| start_refused | output | 1 | Sticky refusal flag |
| req_err | output | 1 | One-cycle pulse for a request that is ignored |

## Verification
The hardest case to reach is a queued start that fires exactly `BUF_CYCLES` after another master's stop. The bench plays the other master on its own open-drain drivers: it pulls SDA and then SCL low to claim the bus, makes the request with `resv_en` set, and later walks SCL and SDA back up in stop order. A repeated start needs a similar setup. The bench first wins the bus, then imitates the byte engine by holding SCL low with `in_wait` raised, and releases both together. A behavioural model in the bench, built on a queue of expected line steps, predicts every output on every cycle, including the first cycle of the fired start.

// File: rtl/i2c_sc_pkg.sv
package i2c_sc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_QUEUED,
        S_RS_WAIT,
        S_RS_DATA,
        S_RS_CLOCK,
        S_SDA_LOW,
        S_SCL_LOW
    } sc_state_e;

    typedef enum logic [2:0] {
        REQ_NONE,
        REQ_ILLEGAL,
        REQ_START,
        REQ_RESTART,
        REQ_RESERVE,
        REQ_REFUSE
    } req_kind_e;

endpackage

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch #(
    parameter int unsigned BUF_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_in,
    input  logic scl_in,
    output logic stop_seen,
    output logic bus_free
);
    localparam int unsigned CW = $clog2(BUF_CYCLES + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(BUF_CYCLES);

    logic          sda_q, scl_q, busy_q, start_seen;
    logic [CW-1:0] quiet_cnt;

    assign start_seen = scl_q && scl_in && sda_q && !sda_in;
    assign stop_seen  = scl_q && scl_in && !sda_q && sda_in;
    assign bus_free   = !busy_q && (quiet_cnt == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_q     <= 1'b1;
            scl_q     <= 1'b1;
            busy_q    <= 1'b0;
            quiet_cnt <= CNT_MAX;
        end else begin
            sda_q <= sda_in;
            scl_q <= scl_in;
            if (busy_q || start_seen)
                quiet_cnt <= '0;
            else if (quiet_cnt != CNT_MAX)
                quiet_cnt <= quiet_cnt + 1'b1;
            if (start_seen)
                busy_q <= 1'b1;
            else if (stop_seen)
                busy_q <= 1'b0;
        end
    end

    assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> !bus_free);

endmodule

// File: rtl/i2c_hold_timer.sv
module i2c_hold_timer #(
    parameter int unsigned HOLD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);
    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign expired = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/i2c_req_sort.sv
module i2c_req_sort
    import i2c_sc_pkg::*;
(
    input  logic      start_req,
    input  logic      stop_req,
    input  logic      idle,
    input  logic      master,
    input  logic      in_wait,
    input  logic      ack_phase,
    input  logic      rx_mode,
    input  logic      ack_en,
    input  logic      last_rx,
    input  logic      bus_free,
    input  logic      resv_en,
    output req_kind_e kind
);
    logic wait_ok;

    assign wait_ok = in_wait && !ack_phase && (!rx_mode || (!ack_en && last_rx));

    always_comb begin
        if (!start_req)
            kind = REQ_NONE;
        else if (stop_req || !idle)
            kind = REQ_ILLEGAL;
        else if (master)
            kind = wait_ok ? REQ_RESTART : REQ_ILLEGAL;
        else if (bus_free)
            kind = REQ_START;
        else if (resv_en)
            kind = REQ_RESERVE;
        else
            kind = REQ_REFUSE;
    end

endmodule

// File: rtl/i2c_start_ctrl.sv
module i2c_start_ctrl
    import i2c_sc_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 4,
    parameter int unsigned BUF_CYCLES  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start_req,
    input  logic stop_req,
    input  logic release_cmd,
    input  logic arb_lost,
    input  logic resv_en,
    input  logic in_wait,
    input  logic ack_phase,
    input  logic rx_mode,
    input  logic ack_en,
    input  logic last_rx,
    input  logic clr_flag,
    input  logic sda_in,
    input  logic scl_in,
    output logic sda_oe,
    output logic scl_oe,
    output logic start_done,
    output logic req_pending,
    output logic is_master,
    output logic start_refused,
    output logic req_err
);
    sc_state_e state_q, state_d;
    req_kind_e kind;
    logic      abort, hold_exp, stop_seen, bus_free;
    logic      master_q, refused_q, err_q;

    assign abort = !enable || arb_lost || release_cmd;

    i2c_bus_watch #(.BUF_CYCLES(BUF_CYCLES)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_in    (sda_in),
        .scl_in    (scl_in),
        .stop_seen (stop_seen),
        .bus_free  (bus_free)
    );

    i2c_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .expired (hold_exp)
    );

    i2c_req_sort u_sort (
        .start_req (start_req),
        .stop_req  (stop_req),
        .idle      (state_q == S_IDLE),
        .master    (master_q),
        .in_wait   (in_wait),
        .ack_phase (ack_phase),
        .rx_mode   (rx_mode),
        .ack_en    (ack_en),
        .last_rx   (last_rx),
        .bus_free  (bus_free),
        .resv_en   (resv_en),
        .kind      (kind)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (kind == REQ_START)        state_d = S_SDA_LOW;
                    else if (kind == REQ_RESTART) state_d = S_RS_WAIT;
                    else if (kind == REQ_RESERVE) state_d = S_QUEUED;
                end
                S_QUEUED:   if (bus_free) state_d = S_SDA_LOW;
                S_RS_WAIT:  if (!in_wait) state_d = S_RS_DATA;
                S_RS_DATA:  if (hold_exp) state_d = S_RS_CLOCK;
                S_RS_CLOCK: if (hold_exp) state_d = S_SDA_LOW;
                S_SDA_LOW:  if (hold_exp) state_d = S_SCL_LOW;
                S_SCL_LOW:  state_d = S_IDLE;
                default:    state_d = S_IDLE;
            endcase
        end
    end

    // Moore outputs
    always_comb begin
        sda_oe     = 1'b0;
        scl_oe     = 1'b0;
        start_done = 1'b0;
        unique case (state_q)
            S_IDLE, S_QUEUED, S_RS_CLOCK: ;
            S_RS_WAIT, S_RS_DATA:         scl_oe = 1'b1;
            S_SDA_LOW:                    sda_oe = 1'b1;
            S_SCL_LOW: begin
                sda_oe     = 1'b1;
                scl_oe     = 1'b1;
                start_done = 1'b1;
            end
            default: ;
        endcase
    end

    // Ownership, refusal flag and error pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            master_q  <= 1'b0;
            refused_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            if (abort)
                master_q <= 1'b0;
            else if (state_q == S_SCL_LOW)
                master_q <= 1'b1;
            else if (stop_seen)
                master_q <= 1'b0;
            if (!abort && kind == REQ_REFUSE)
                refused_q <= 1'b1;
            else if (clr_flag)
                refused_q <= 1'b0;
            err_q <= !abort && (kind == REQ_ILLEGAL);
        end
    end

    assign req_pending   = (state_q != S_IDLE);
    assign is_master     = master_q;
    assign start_refused = refused_q;
    assign req_err       = err_q;

    assert_master_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_done && !abort) |=> is_master);
    assert_restart_releases_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RS_WAIT && !in_wait && !abort) |=> (!sda_oe && scl_oe));
    assert_queued_fires_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_QUEUED && bus_free && !abort) |=> (sda_oe && !scl_oe));
    assert_refuse_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == REQ_REFUSE && !abort) |=> (start_refused && !req_pending));
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_refused && !clr_flag) |=> start_refused);
    assert_abort_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!req_pending && !is_master && !sda_oe && !scl_oe));
    assert_bad_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && is_master && !in_wait && !abort) |=> req_err);
    assert_dual_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && stop_req && !abort) |=> req_err);

endmodule

// File: tb/i2c_start_ctrl_test.sv
`timescale 1ns/1ps
module i2c_start_ctrl_test;
    localparam int HOLD = 3;
    localparam int BUFC = 4;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1, start_req = 1'b0, stop_req = 1'b0, release_cmd = 1'b0;
    logic arb_lost = 1'b0, resv_en = 1'b0, in_wait = 1'b0, ack_phase = 1'b0;
    logic rx_mode = 1'b0, ack_en = 1'b0, last_rx = 1'b0, clr_flag = 1'b0;
    logic ext_sda_low = 1'b0, ext_scl_low = 1'b0;
    logic sda_oe, scl_oe, start_done, req_pending, is_master, start_refused, req_err;
    logic sda_bus, scl_bus;

    assign sda_bus = !(sda_oe || ext_sda_low);
    assign scl_bus = !(scl_oe || ext_scl_low);

    always #10 clk = ~clk;

    i2c_start_ctrl #(.HOLD_CYCLES(HOLD), .BUF_CYCLES(BUFC)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start_req(start_req),
        .stop_req(stop_req), .release_cmd(release_cmd), .arb_lost(arb_lost),
        .resv_en(resv_en), .in_wait(in_wait), .ack_phase(ack_phase),
        .rx_mode(rx_mode), .ack_en(ack_en), .last_rx(last_rx), .clr_flag(clr_flag),
        .sda_in(sda_bus), .scl_in(scl_bus), .sda_oe(sda_oe), .scl_oe(scl_oe),
        .start_done(start_done), .req_pending(req_pending), .is_master(is_master),
        .start_refused(start_refused), .req_err(req_err)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;
    string cur_r = "R10";

    // Behavioural reference model: mode 0 idle, 1 queued, 2 restart wait, 3 playing steps
    logic [2:0] q[$];     // {done, sda pulled, scl pulled}
    int  m_mode, m_cnt, prev_mode;
    bit  m_master, m_flag, m_err, m_busy, m_psda, m_pscl;
    bit  l_sda, l_scl, st_det, sp_det, free_old, set_now, refuse, tok, old_busy;
    logic [2:0] o, popped;

    function automatic logic [2:0] m_out();
        if (m_mode == 3 && q.size() > 0) return q[0];
        if (m_mode == 2) return 3'b001;
        return 3'b000;
    endfunction

    task automatic push_start();
        for (int i = 0; i < HOLD; i++) q.push_back(3'b010);
        q.push_back(3'b111);
    endtask

    task automatic push_restart();
        for (int i = 0; i < HOLD; i++) q.push_back(3'b001);
        for (int i = 0; i < HOLD; i++) q.push_back(3'b000);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; q.delete(); m_master = 0; m_flag = 0; m_err = 0;
            m_busy = 0; m_cnt = BUFC; m_psda = 1; m_pscl = 1;
        end else begin
            o = m_out();
            l_sda = !(o[1] || ext_sda_low);
            l_scl = !(o[0] || ext_scl_low);
            st_det = m_pscl && l_scl && m_psda && !l_sda;
            sp_det = m_pscl && l_scl && !m_psda && l_sda;
            free_old = !m_busy && (m_cnt == BUFC);
            set_now = 0; refuse = 0; m_err = 0;
            prev_mode = m_mode;
            if (!enable || arb_lost || release_cmd) begin
                m_mode = 0; q.delete(); m_master = 0;
            end else begin
                if (prev_mode == 3) begin
                    popped = q.pop_front();
                    if (popped[2]) begin m_mode = 0; m_master = 1; set_now = 1; end
                end else if (prev_mode == 1) begin
                    if (free_old) begin m_mode = 3; push_start(); end
                end else if (prev_mode == 2) begin
                    if (!in_wait) begin m_mode = 3; push_restart(); push_start(); end
                end
                if (start_req) begin
                    if (stop_req || prev_mode != 0) m_err = 1;
                    else if (m_master) begin
                        tok = in_wait && !ack_phase && (!rx_mode || (!ack_en && last_rx));
                        if (tok) m_mode = 2; else m_err = 1;
                    end else if (free_old) begin m_mode = 3; push_start(); end
                    else if (resv_en) m_mode = 1;
                    else refuse = 1;
                end
            end
            if (refuse) m_flag = 1;
            else if (clr_flag) m_flag = 0;
            if (sp_det && !set_now) m_master = 0;
            old_busy = m_busy;
            if (old_busy || st_det) m_cnt = 0;
            else if (m_cnt != BUFC) m_cnt = m_cnt + 1;
            if (st_det) m_busy = 1;
            else if (sp_det) m_busy = 0;
            m_psda = l_sda;
            m_pscl = l_scl;
        end
    end

    task automatic cmp(string what, logic act, logic exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", cur_r, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [2:0] e;
            e = m_out();
            checks++;
            cmp("sda_oe", sda_oe, e[1]);
            cmp("scl_oe", scl_oe, e[0]);
            cmp("start_done", start_done, e[2]);
            cmp("req_pending", req_pending, m_mode != 0);
            cmp("is_master", is_master, m_master);
            cmp("start_refused", start_refused, m_flag);
            cmp("req_err", req_err, m_err);
        end
    end

    task automatic chk(string r, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", r, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_req = 1'b1; tick(1); start_req = 1'b0;
    endtask

    task automatic other_start();
        ext_sda_low = 1'b1; tick(1); ext_scl_low = 1'b1; tick(1);
    endtask

    task automatic bus_stop();
        ext_scl_low = 1'b1; tick(1);
        ext_sda_low = 1'b1; tick(1);
        ext_scl_low = 1'b0; tick(1);
        ext_sda_low = 1'b0; tick(1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            errors++;
            $display("FAIL %s watchdog: actual %0d cycles expected under %0d", cur_r, cycles, WATCHDOG);
            summary();
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R10 reset state
        chk("R10", "sda_oe", sda_oe, 1'b0);
        chk("R10", "req_pending", req_pending, 1'b0);
        chk("R10", "is_master", is_master, 1'b0);
        chk("R10", "start_refused", start_refused, 1'b0);

        // R1 start on a free bus
        cur_r = "R1";
        pulse_start();
        chk("R1", "sda_oe in first hold cycle", sda_oe, 1'b1);
        chk("R1", "scl_oe in first hold cycle", scl_oe, 1'b0);
        tick(HOLD);
        chk("R1", "start_done", start_done, 1'b1);
        tick(1);
        chk("R1", "is_master", is_master, 1'b1);

        // R9 stop clears ownership; early request counts as busy
        cur_r = "R9";
        bus_stop();
        chk("R9", "is_master after stop", is_master, 1'b0);
        pulse_start();
        chk("R9", "refused inside free time", start_refused, 1'b1);
        chk("R9", "no start inside free time", sda_oe, 1'b0);
        clr_flag = 1'b1; tick(1); clr_flag = 1'b0;
        chk("R5", "flag cleared by pulse", start_refused, 1'b0);
        tick(BUFC + 2);

        // R2 repeated start after the wait
        cur_r = "R2";
        pulse_start();
        tick(HOLD + 1);
        in_wait = 1'b1; ext_scl_low = 1'b1; tick(2);
        pulse_start();
        chk("R2", "pending in restart wait", req_pending, 1'b1);
        chk("R2", "clock held low", scl_oe, 1'b1);
        cur_r = "R8";
        pulse_start();
        chk("R8", "re-request error", req_err, 1'b1);
        cur_r = "R2";
        in_wait = 1'b0; ext_scl_low = 1'b0; tick(1);
        chk("R2", "sda released with clock low", sda_oe, 1'b0);
        chk("R2", "scl held", scl_oe, 1'b1);
        tick(HOLD);
        chk("R2", "scl released", scl_oe, 1'b0);
        tick(HOLD);
        chk("R2", "sda pulled", sda_oe, 1'b1);
        tick(HOLD + 1);
        chk("R2", "still master", is_master, 1'b1);

        // R7 timing rules for a master request
        cur_r = "R7";
        pulse_start();
        chk("R7", "err outside wait", req_err, 1'b1);
        chk("R7", "no pending outside wait", req_pending, 1'b0);
        in_wait = 1'b1; ext_scl_low = 1'b1; ack_phase = 1'b1;
        pulse_start();
        chk("R7", "err in ack period", req_err, 1'b1);
        ack_phase = 1'b0; rx_mode = 1'b1; ack_en = 1'b1; last_rx = 1'b1;
        pulse_start();
        chk("R7", "err rx with ack enabled", req_err, 1'b1);
        ack_en = 1'b0;
        pulse_start();
        chk("R7", "rx accepted", req_pending, 1'b1);
        cur_r = "R6";
        release_cmd = 1'b1; tick(1); release_cmd = 1'b0;
        chk("R6", "release drops request", req_pending, 1'b0);
        chk("R6", "release clears master", is_master, 1'b0);
        in_wait = 1'b0; rx_mode = 1'b0; last_rx = 1'b0; ext_scl_low = 1'b0;
        tick(1);
        bus_stop();
        tick(BUFC + 2);

        // R8 start with stop
        cur_r = "R8";
        stop_req = 1'b1; pulse_start(); stop_req = 1'b0;
        chk("R8", "dual request error", req_err, 1'b1);
        chk("R8", "dual request ignored", req_pending, 1'b0);
        tick(2);

        // R3 reservation fires after bus free time
        cur_r = "R3";
        other_start(); tick(1);
        resv_en = 1'b1;
        pulse_start();
        chk("R3", "queued", req_pending, 1'b1);
        tick(4);
        chk("R3", "no start while busy", sda_oe, 1'b0);
        bus_stop();
        tick(BUFC);
        chk("R3", "not yet fired", sda_oe, 1'b0);
        tick(1);
        chk("R3", "fired", sda_oe, 1'b1);
        tick(HOLD + 1);
        chk("R3", "master after queued start", is_master, 1'b1);
        bus_stop();
        tick(BUFC + 2);

        // R4 / R5 refusal and sticky flag
        cur_r = "R4";
        resv_en = 1'b0;
        other_start(); tick(1);
        pulse_start();
        chk("R4", "flag set", start_refused, 1'b1);
        chk("R4", "no pending", req_pending, 1'b0);
        cur_r = "R5";
        tick(5);
        chk("R5", "flag sticky", start_refused, 1'b1);
        clr_flag = 1'b1; pulse_start(); clr_flag = 1'b0;
        chk("R5", "set wins over clear", start_refused, 1'b1);
        clr_flag = 1'b1; tick(1); clr_flag = 1'b0;
        chk("R5", "cleared", start_refused, 1'b0);

        // R6 arbitration loss and disable
        cur_r = "R6";
        resv_en = 1'b1;
        pulse_start();
        arb_lost = 1'b1; tick(1); arb_lost = 1'b0;
        chk("R6", "arb loss drops queue", req_pending, 1'b0);
        bus_stop();
        tick(BUFC + 2);
        pulse_start();
        tick(1);
        enable = 1'b0; tick(1);
        chk("R6", "disable releases sda", sda_oe, 1'b0);
        chk("R6", "disable drops request", req_pending, 1'b0);
        enable = 1'b1;
        tick(BUFC + 3);

        summary();
    end
endmodule